// File: doc/BRIEF.md
# Four-Channel Compare Alarm Bank

This block holds four independent alarms that watch a free-running 32-bit time word supplied from outside. Software loads a target value into an alarm's compare register, and that write also arms the alarm. When an armed alarm's target equals the incoming time word, the alarm fires. Firing latches a raw interrupt flag and disarms the alarm, so the alarm fires once per arming.

Software can drop an alarm before it fires. It acknowledges flags by writing ones to them. It masks them through an enable register and can raise any interrupt line through a force register. Each alarm drives its own level interrupt line, registered from (raw AND enable) OR force. A lock input turns every register write into a no-op, while reads still work.

Top module: `cmp_alarm_bank`

## Requirements
- R1: A write to address i (0..3) stores the write data in compare register i and sets armed bit i. Reading address i returns the stored value.
- R2: When armed bit i is set and compare register i equals `time_lo`, the next clock edge does two things: it clears armed bit i and it sets raw bit i.
- R3: Matching is by equality only. An armed alarm whose target is not equal to `time_lo` stays armed and raises nothing, even if the time word has already passed the target.
- R4: Writing the armed register (address 4) disarms every alarm whose data bit is 1, with no interrupt raised. Data bits that are 0 leave their alarms as they were.
- R5: If a disarm write and a match for the same alarm occur in one cycle, the disarm wins: the alarm is disarmed and its raw bit stays 0.
- R6: Writing address 5 clears each raw bit whose data bit is 1. Bits written 0 are unchanged. A fire in the same cycle takes precedence over the clear.
- R7: The enable register (address 6) and the force register (address 7) take written values directly. Address 8 reads the status (raw AND enable) OR force. `irq_o` equals that status one clock later.
- R8: While `lock` is 1, every write is ignored.
- R9: After reset, the following are all zero: the compare, armed, raw, enable and force registers, `irq_o`, `rd_data` and `rd_valid`.
- R10: A read with `rd_en` high returns the addressed register on `rd_data`, with `rd_valid` high one cycle later. Unmapped addresses read 0. Control registers sit in bits 3:0, one bit per alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_lo | input | 32 | Low word of the time counter |
| lock | input | 1 | Blocks all register writes when high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read strobe |
| irq_o | output | 4 | Per-alarm level interrupt |

## Verification
The assertions check the following on every cycle:
- a compare write arms its alarm;
- a fire disarms the alarm and latches the raw flag;
- an unmatched alarm stays armed;
- a clear leaves no flag behind unless a fire occurred;
- a forced bit reaches `irq_o`;
- a locked write changes neither the enable or force registers nor arms anything.

Some behaviour only the bench scenarios can show. These are a target already passed that fires only on a later exact match, the disarm-wins collision with a match, masking by the enable register, and the read map.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  // Control register offsets above the compare registers
  localparam int OFS_ARMED = 0;
  localparam int OFS_RAW   = 1;
  localparam int OFS_EN    = 2;
  localparam int OFS_FRC   = 3;
  localparam int OFS_STAT  = 4;
  localparam int NUM_CTRL  = 5;
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_lo,
  input  logic              cmp_wr,
  input  logic [TIME_W-1:0] wdata,
  input  logic              disarm,
  output logic              armed,
  output logic [TIME_W-1:0] cmp,
  output logic              fire
);
  logic              armed_q;
  logic [TIME_W-1:0] cmp_q;
  logic              hit;

  assign hit  = (cmp_q == time_lo);
  assign fire = armed_q & hit & ~disarm & ~cmp_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cmp_q   <= '0;
    end else if (cmp_wr) begin
      cmp_q   <= wdata;
      armed_q <= 1'b1;
    end else if (disarm || fire) begin
      armed_q <= 1'b0;
    end
  end

  assign armed = armed_q;
  assign cmp   = cmp_q;

  // R1: a compare write arms and stores
  a_r1_write_arms: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (armed_q && cmp_q == $past(wdata)));
  // R2: a match on an armed alarm disarms it
  a_r2_fire_disarms: assert property (@(posedge clk) disable iff (rst)
    (armed_q && hit && !disarm && !cmp_wr) |=> !armed_q);
  // R3: no match keeps it armed
  a_r3_no_match_holds: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !hit && !disarm && !cmp_wr) |=> armed_q);
  // R4: disarm write drops the alarm
  a_r4_disarm: assert property (@(posedge clk) disable iff (rst)
    (disarm && !cmp_wr) |=> !armed_q);
endmodule

// File: rtl/alarm_irq_bank.sv
module alarm_irq_bank #(
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] fire,
  input  logic [NUM-1:0] raw_clr,
  input  logic           en_we,
  input  logic           frc_we,
  input  logic [NUM-1:0] wbits,
  output logic [NUM-1:0] raw,
  output logic [NUM-1:0] en,
  output logic [NUM-1:0] frc,
  output logic [NUM-1:0] status,
  output logic [NUM-1:0] irq
);
  logic [NUM-1:0] raw_q, en_q, frc_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      frc_q <= '0;
      irq_q <= '0;
    end else begin
      raw_q <= (raw_q & ~raw_clr) | fire;
      if (en_we)  en_q  <= wbits;
      if (frc_we) frc_q <= wbits;
      irq_q <= status;
    end
  end

  assign status = (raw_q & en_q) | frc_q;
  assign raw    = raw_q;
  assign en     = en_q;
  assign frc    = frc_q;
  assign irq    = irq_q;

  // R2: a fire latches its raw flag
  a_r2_fire_sets_raw: assert property (@(posedge clk) disable iff (rst)
    (|fire) |=> ((raw_q & $past(fire)) == $past(fire)));
  // R6: a clear with no fire leaves the flag low
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (|(raw_clr & ~fire)) |=> ((raw_q & $past(raw_clr & ~fire)) == '0));
  // R7: a forced bit reaches the interrupt line
  a_r7_force_drives_irq: assert property (@(posedge clk) disable iff (rst)
    (|frc_q) |=> ((irq_q & $past(frc_q)) == $past(frc_q)));
endmodule

// File: rtl/cmp_alarm_bank.sv
module cmp_alarm_bank #(
  parameter int NUM_ALARMS = 4,
  parameter int TIME_W     = 32,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TIME_W-1:0]     time_lo,
  input  logic                  lock,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [TIME_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [TIME_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [NUM_ALARMS-1:0] irq_o
);
  import alarm_pkg::*;

  localparam logic [ADDR_W-1:0] A_ARMED = ADDR_W'(NUM_ALARMS + OFS_ARMED);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(NUM_ALARMS + OFS_RAW);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(NUM_ALARMS + OFS_EN);
  localparam logic [ADDR_W-1:0] A_FRC   = ADDR_W'(NUM_ALARMS + OFS_FRC);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(NUM_ALARMS + OFS_STAT);

  logic                  wr_ok;
  logic [NUM_ALARMS-1:0] armed, fire, raw, en, frc, status;
  logic [NUM_ALARMS-1:0] wbits;
  logic [TIME_W-1:0]     cmp_arr [NUM_ALARMS];
  logic [TIME_W-1:0]     rd_mux;
  logic [TIME_W-1:0]     rd_q;
  logic                  rd_v_q;

  assign wr_ok = wr_en & ~lock;
  assign wbits = wr_data[NUM_ALARMS-1:0];

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_ch
    alarm_channel #(.TIME_W(TIME_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .time_lo (time_lo),
      .cmp_wr  (wr_ok && (wr_addr == ADDR_W'(i))),
      .wdata   (wr_data),
      .disarm  (wr_ok && (wr_addr == A_ARMED) && wbits[i]),
      .armed   (armed[i]),
      .cmp     (cmp_arr[i]),
      .fire    (fire[i])
    );
  end

  alarm_irq_bank #(.NUM(NUM_ALARMS)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .raw_clr ((wr_ok && wr_addr == A_RAW) ? wbits : '0),
    .en_we   (wr_ok && wr_addr == A_EN),
    .frc_we  (wr_ok && wr_addr == A_FRC),
    .wbits   (wbits),
    .raw     (raw),
    .en      (en),
    .frc     (frc),
    .status  (status),
    .irq     (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_ALARMS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_mux = cmp_arr[i];
    end
    if (rd_addr == A_ARMED) rd_mux = TIME_W'(armed);
    if (rd_addr == A_RAW)   rd_mux = TIME_W'(raw);
    if (rd_addr == A_EN)    rd_mux = TIME_W'(en);
    if (rd_addr == A_FRC)   rd_mux = TIME_W'(frc);
    if (rd_addr == A_STAT)  rd_mux = TIME_W'(status);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      rd_v_q <= 1'b0;
    end else begin
      rd_v_q <= rd_en;
      if (rd_en) rd_q <= rd_mux;
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rd_v_q;

  // R8: locked writes leave enable/force alone and arm nothing
  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    (lock && wr_en) |=> ($stable(en) && $stable(frc) && ((armed & ~$past(armed)) == '0)));
  // R10: valid follows the strobe
  a_r10_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/cmp_alarm_bank_tb.sv
`timescale 1ns/1ps
module cmp_alarm_bank_tb;
  localparam int AW = 4;
  localparam logic [3:0] A_ARMED = 4, A_RAW = 5, A_EN = 6, A_FRC = 7, A_STAT = 8;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] time_lo = 0;
  logic        lock = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        rd_en = 0;
  logic [3:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [3:0]  q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  cmp_alarm_bank #(.NUM_ALARMS(4), .TIME_W(32), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .time_lo(time_lo), .lock(lock),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_o(irq_o)
  );

  // Monitor: pop expected reads and compare
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_chk++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected read: actual=%h expected=none", rd_data);
      end else begin
        logic [3:0] a;
        logic [31:0] e;
        string t;
        a = q_addr.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", t, a, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(t);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic set_time(input logic [31:0] v);
    @(negedge clk);
    time_lo = v;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s irq_o actual=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9: reset state
    chk_irq(4'b0000, "R9");
    n_chk++;
    if (rd_valid !== 1'b0 || rd_data !== 32'h0) begin
      n_fail++;
      $display("FAIL R9 rd port actual=%b/%h expected=0/0", rd_valid, rd_data);
    end
    rd(A_ARMED, 0, "R9");
    rd(A_RAW, 0, "R9");
    rd(4'd0, 0, "R9");
    rd(4'd12, 0, "R10");

    // R1 / R2: arm and fire
    wr(A_EN, 32'hF);
    rd(A_EN, 32'hF, "R7");
    set_time(10);
    wr(4'd0, 100);
    rd(A_ARMED, 32'h1, "R1");
    rd(4'd0, 100, "R1");
    set_time(100);
    rd(A_ARMED, 0, "R2");
    rd(A_RAW, 32'h1, "R2");
    chk_irq(4'b0001, "R7");
    // R6: write-one-to-clear
    wr(A_RAW, 32'h1);
    rd(A_RAW, 0, "R6");
    chk_irq(4'b0000, "R6");

    // R3: target already passed
    wr(4'd1, 50);
    set_time(60);
    set_time(99);
    rd(A_ARMED, 32'h2, "R3");
    rd(A_RAW, 0, "R3");
    set_time(50);
    set_time(51);
    rd(A_RAW, 32'h2, "R3");
    chk_irq(4'b0010, "R3");
    wr(A_RAW, 32'h2);

    // R4: early disarm, zero bits untouched
    wr(4'd2, 200);
    wr(4'd3, 300);
    wr(A_ARMED, 32'h4);
    rd(A_ARMED, 32'h8, "R4");
    set_time(200);
    set_time(201);
    rd(A_RAW, 0, "R4");

    // R5: disarm collides with match
    set_time(299);
    @(negedge clk);
    time_lo = 300; wr_en = 1; wr_addr = A_ARMED; wr_data = 32'h8;
    @(negedge clk);
    wr_en = 0; time_lo = 301;
    rd(A_ARMED, 0, "R5");
    rd(A_RAW, 0, "R5");
    chk_irq(4'b0000, "R5");

    // R7: mask and force
    wr(A_EN, 32'h0);
    wr(4'd0, 500);
    set_time(500);
    set_time(501);
    rd(A_RAW, 32'h1, "R7");
    rd(A_STAT, 0, "R7");
    chk_irq(4'b0000, "R7");
    wr(A_FRC, 32'h2);
    rd(A_STAT, 32'h2, "R7");
    chk_irq(4'b0010, "R7");
    wr(A_EN, 32'h1);
    rd(A_STAT, 32'h3, "R7");
    chk_irq(4'b0011, "R7");
    wr(A_FRC, 32'h0);
    wr(A_RAW, 32'h1);
    rd(A_STAT, 0, "R6");

    // R8: lock
    @(negedge clk);
    lock = 1;
    wr(4'd0, 7);
    wr(A_EN, 32'hF);
    wr(A_FRC, 32'hF);
    rd(4'd0, 500, "R8");
    rd(A_ARMED, 0, "R8");
    rd(A_EN, 32'h1, "R8");
    chk_irq(4'b0000, "R8");

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 reads outstanding actual=%0d expected=0", q_exp.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule